// File: doc/BRIEF.md
# Cross-Domain Peripheral Control Register

This block is the control and status front end of a peripheral whose working logic is clocked separately from the register bus. Software writes a control register through a plain write/read port in the bus domain. The enable bit and the software-reset bit each reach the core domain through a toggle handshake. A busy flag for each one stays set from the accepted write until the core domain has acted on it and its acknowledge has come back.

Four retained registers hold gain, offset, calibration and debug-control values. A software reset does not touch them. Only the bus-side hardware reset clears them. The block also combines the run-in-standby bit, a free-run input and a request input into a qualifier. That qualifier tells the power logic whether the peripheral should keep running in standby.

Top module: `periph_ctrl_sync`

## Requirements
- R1: After the bus-side and core-side resets, every mapped register reads 0x00, `core_enable` is 0 and `stby_run` is 0.
- R2: CTRL (offset 0x00) holds run-in-standby at bit 6, enable at bit 1 and software reset at bit 0. Every other CTRL bit reads 0, and so does any unmapped offset (for example 0x1C). A value written to the enable bit reads back in the cycle after the write.
- R3: An accepted CTRL write sets BUSY (offset 0x04) bit 1 in the cycle after the write. Bit 1 clears only after `core_enable` has taken the written enable value.
- R4: While BUSY bit 1 is set, the enable bit of a CTRL write is ignored and `core_enable` keeps the value of the handshake already under way. The run-in-standby bit of that write still takes effect.
- R5: A CTRL write with bit 0 at 0 starts no reset.
- R6: A CTRL write with bit 0 at 1 discards the other bits of that write and clears enable and run-in-standby. CTRL bit 0 and BUSY bit 0 then read 1, and both clear together once the core domain has forced `core_enable` to 0.
- R7: Any CTRL write that arrives while BUSY bit 0 is set is ignored.
- R8: GAIN (0x08), OFFSET (0x0C), CAL (0x10) and DBGCTRL (0x14) are 8-bit read/write registers. They keep their contents through a software reset.
- R9: `stby_run` equals run-in-standby AND (`free_run` OR `periph_req`). It follows these inputs in the same cycle, with no synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| core_clk | input | 1 | Peripheral core clock, unrelated to bus_clk |
| core_rst_n | input | 1 | Asynchronous active-low reset, core domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| free_run | input | 1 | Free-running mode from the peripheral configuration |
| periph_req | input | 1 | Another unit requests the peripheral |
| stby_run | output | 1 | Peripheral may keep running in standby |
| core_enable | output | 1 | Enable state applied in the core domain |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` change only between bus clock edges, and that both resets are asserted together at start-up. The bench meets this by driving every bus input on the falling edge of `bus_clk`, and by holding both resets low for several cycles of each clock. The assertions also assume the core clock runs. Otherwise a busy flag never clears, and the bench would count that as a polling timeout. The random phase keeps CTRL bit 0 and the enable bit at 0, so the enable and reset handshakes are exercised only by the directed steps, whose timing is known.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 5;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_BUSY = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_GAIN = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_OFST = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CAL  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_DBG  = 5'h14;

    // bit positions
    localparam int unsigned CTRL_RST_BIT = 0;
    localparam int unsigned CTRL_EN_BIT  = 1;
    localparam int unsigned CTRL_RS_BIT  = 6;
    localparam int unsigned BUSY_RST_BIT = 0;
    localparam int unsigned BUSY_EN_BIT  = 1;

    // handshake channel indices
    localparam int unsigned CH_RST = 0;
    localparam int unsigned CH_EN  = 1;
    localparam int unsigned N_CH   = 2;

    typedef struct packed {
        logic run_stby;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [REG_W-1:0] gain;
        logic [REG_W-1:0] ofst;
        logic [REG_W-1:0] cal;
        logic [REG_W-1:0] dbg;
    } keep_t;

endpackage

// File: rtl/pcs_bit_sync.sv
module pcs_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pcs_core_side.sv
module pcs_core_side (
    input  logic core_clk,
    input  logic core_rst_n,
    input  logic en_req_s,
    input  logic rst_req_s,
    input  logic en_level,
    output logic en_ack,
    output logic rst_ack,
    output logic core_enable
);

    typedef struct packed {
        logic en;
        logic en_ack;
        logic rst_ack;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // enable request: latch the quasi-static level from the bus side
        if (en_req_s != st_q.en_ack) begin
            st_d.en     = en_level;
            st_d.en_ack = en_req_s;
        end
        // reset request wins when both arrive together
        if (rst_req_s != st_q.rst_ack) begin
            st_d.en      = 1'b0;
            st_d.rst_ack = rst_req_s;
        end
    end

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_ack      = st_q.en_ack;
    assign rst_ack     = st_q.rst_ack;
    assign core_enable = st_q.en;

endmodule

// File: rtl/pcs_regs.sv
module pcs_regs
    import pcs_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              en_ack_s,
    input  logic              rst_ack_s,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output keep_t             keep,
    output logic              busy_en,
    output logic              busy_rst,
    output logic              en_req,
    output logic              rst_req
);

    typedef struct packed {
        ctrl_t ctrl;
        keep_t keep;
        logic  en_req;
        logic  rst_req;
    } bus_st_t;

    bus_st_t st_d, st_q;

    assign busy_en  = st_q.en_req ^ en_ack_s;
    assign busy_rst = st_q.rst_req ^ rst_ack_s;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                OFS_CTRL: begin
                    if (!busy_rst) begin
                        if (wdata[CTRL_RST_BIT]) begin
                            st_d.ctrl    = '0;
                            st_d.rst_req = ~st_q.rst_req;
                        end else begin
                            st_d.ctrl.run_stby = wdata[CTRL_RS_BIT];
                            if (!busy_en) begin
                                st_d.ctrl.enable = wdata[CTRL_EN_BIT];
                                st_d.en_req      = ~st_q.en_req;
                            end
                        end
                    end
                end
                OFS_GAIN: st_d.keep.gain = wdata;
                OFS_OFST: st_d.keep.ofst = wdata;
                OFS_CAL:  st_d.keep.cal  = wdata;
                OFS_DBG:  st_d.keep.dbg  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[CTRL_RS_BIT]  = st_q.ctrl.run_stby;
                rdata[CTRL_EN_BIT]  = st_q.ctrl.enable;
                rdata[CTRL_RST_BIT] = busy_rst;
            end
            OFS_BUSY: begin
                rdata[BUSY_EN_BIT]  = busy_en;
                rdata[BUSY_RST_BIT] = busy_rst;
            end
            OFS_GAIN: rdata = st_q.keep.gain;
            OFS_OFST: rdata = st_q.keep.ofst;
            OFS_CAL:  rdata = st_q.keep.cal;
            OFS_DBG:  rdata = st_q.keep.dbg;
            default:  rdata = '0;
        endcase
    end

    assign ctrl    = st_q.ctrl;
    assign keep    = st_q.keep;
    assign en_req  = st_q.en_req;
    assign rst_req = st_q.rst_req;

endmodule

// File: rtl/periph_ctrl_sync.sv
module periph_ctrl_sync
    import pcs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              core_clk,
    input  logic              core_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              free_run,
    input  logic              periph_req,
    output logic              stby_run,
    output logic              core_enable
);

    ctrl_t            ctrl;
    keep_t            keep;
    logic             busy_en;
    logic             busy_rst;
    logic [N_CH-1:0]  req_tgl;
    logic [N_CH-1:0]  req_s;
    logic [N_CH-1:0]  ack_tgl;
    logic [N_CH-1:0]  ack_s;

    pcs_regs u_regs (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .en_ack_s  (ack_s[CH_EN]),
        .rst_ack_s (ack_s[CH_RST]),
        .rdata     (rdata),
        .ctrl      (ctrl),
        .keep      (keep),
        .busy_en   (busy_en),
        .busy_rst  (busy_rst),
        .en_req    (req_tgl[CH_EN]),
        .rst_req   (req_tgl[CH_RST])
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        pcs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
            .clk   (core_clk),
            .rst_n (core_rst_n),
            .d     (req_tgl[ch]),
            .q     (req_s[ch])
        );
        pcs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
            .clk   (bus_clk),
            .rst_n (bus_rst_n),
            .d     (ack_tgl[ch]),
            .q     (ack_s[ch])
        );
    end

    pcs_core_side u_core (
        .core_clk    (core_clk),
        .core_rst_n  (core_rst_n),
        .en_req_s    (req_s[CH_EN]),
        .rst_req_s   (req_s[CH_RST]),
        .en_level    (ctrl.enable),
        .en_ack      (ack_tgl[CH_EN]),
        .rst_ack     (ack_tgl[CH_RST]),
        .core_enable (core_enable)
    );

    // standby qualifier, taken straight from the bus-side bit
    assign stby_run = ctrl.run_stby & (free_run | periph_req);

endmodule

// File: rtl/periph_ctrl_sync_chk.sv
module periph_ctrl_sync_chk
    import pcs_pkg::*;
(
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic              free_run,
    input logic              stby_run,
    input ctrl_t             ctrl,
    input keep_t             keep,
    input logic              busy_en,
    input logic              busy_rst
);

    logic ctrl_wr;
    logic rst_wr;
    assign ctrl_wr = wr_en && (addr == OFS_CTRL) && !busy_rst;
    assign rst_wr  = ctrl_wr && wdata[CTRL_RST_BIT];

    AST_EN_WRITE_SETS_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        ctrl_wr && !wdata[CTRL_RST_BIT] && !busy_en |=> busy_en && (ctrl.enable == $past(wdata[CTRL_EN_BIT]))); // R3

    AST_EN_FROZEN_WHILE_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy_en && !rst_wr |=> ctrl.enable == $past(ctrl.enable)); // R4

    AST_RESET_DISCARDS_OTHERS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        rst_wr |=> busy_rst && (ctrl == '0)); // R6

    AST_CTRL_LOCKED_IN_RESET: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy_rst |=> $stable(ctrl)); // R7

    AST_KEEP_HOLDS_NO_WRITE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !wr_en |=> $stable(keep)); // R8

    AST_STBY_HALTED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !ctrl.run_stby |-> !stby_run); // R9

    AST_STBY_FREE_RUNS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        ctrl.run_stby && free_run |-> stby_run); // R9

endmodule

bind periph_ctrl_sync periph_ctrl_sync_chk u_chk (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .free_run  (free_run),
    .stby_run  (stby_run),
    .ctrl      (ctrl),
    .keep      (keep),
    .busy_en   (busy_en),
    .busy_rst  (busy_rst)
);

// File: tb/periph_ctrl_sync_tb.sv
module periph_ctrl_sync_tb;

    logic       bus_clk = 1'b0;
    logic       core_clk = 1'b0;
    logic       bus_rst_n = 1'b0;
    logic       core_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       free_run = 1'b0;
    logic       periph_req = 1'b0;
    logic       stby_run;
    logic       core_enable;

    int checks = 0;
    int errors = 0;

    always #5 bus_clk = ~bus_clk;     // 100 MHz
    always #13 core_clk = ~core_clk;  // unrelated core clock

    periph_ctrl_sync u_dut (
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .core_clk    (core_clk),
        .core_rst_n  (core_rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .free_run    (free_run),
        .periph_req  (periph_req),
        .stby_run    (stby_run),
        .core_enable (core_enable)
    );

    function automatic logic exp_stby(input logic rs, input logic fr, input logic rq);
        return rs & (fr | rq);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge bus_clk);
        addr = a;
        #1 d = rdata;
    endtask

    // poll BUSY until the masked bits are clear; returns 1 on success
    task automatic wait_idle(input logic [7:0] mask, output bit ok);
        logic [7:0] v;
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            bus_read(5'h04, v);
            if ((v & mask) == 8'h00) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge bus_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] keep_m [4];
        logic [4:0] keep_a [4];
        logic       rs_m;
        bit         ok;
        keep_a[0] = 5'h08; keep_a[1] = 5'h0C; keep_a[2] = 5'h10; keep_a[3] = 5'h14;
        for (int i = 0; i < 4; i++) keep_m[i] = 8'h00;
        rs_m = 1'b0;
        void'($urandom(32'd1234));

        repeat (4) @(negedge core_clk);
        bus_rst_n = 1'b1;
        core_rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);

        // R1: reset state
        bus_read(5'h00, v); chk("R1 ctrl", v, 8'h00);
        bus_read(5'h04, v); chk("R1 busy", v, 8'h00);
        for (int i = 0; i < 4; i++) begin
            bus_read(keep_a[i], v); chk("R1 retained", v, 8'h00);
        end
        chk("R1 core_enable", core_enable, 1'b0);
        chk("R1 stby_run", stby_run, 1'b0);

        // random phase: retained registers, run-in-standby, qualifier (R8, R9, R5)
        for (int n = 0; n < 40; n++) begin
            int sel;
            logic [7:0] d;
            sel = int'($urandom_range(0, 4));
            d = 8'($urandom);
            if (sel == 4) begin
                d = d & 8'hFC;          // no reset, enable kept 0 (R5)
                bus_write(5'h00, d);
                rs_m = d[6];
                bus_read(5'h00, v); chk("R5 ctrl after write with bit0=0", v, {1'b0, rs_m, 6'b0});
            end else begin
                bus_write(keep_a[sel], d);
                keep_m[sel] = d;
                bus_read(keep_a[sel], v); chk("R8 retained readback", v, d);
            end
            @(negedge bus_clk);
            free_run = 1'($urandom);
            periph_req = 1'($urandom);
            #1 chk("R9 stby_run", stby_run, exp_stby(rs_m, free_run, periph_req));
        end
        wait_idle(8'h03, ok); chk("R3 busy settles", ok, 1'b1);

        // R3: enable handshake
        bus_write(5'h00, 8'h02);
        bus_read(5'h00, v); chk("R2 enable readback", v, 8'h02);
        bus_read(5'h04, v); chk("R3 busy set after write", v, 8'h02);
        wait_idle(8'h02, ok); chk("R3 busy clears", ok, 1'b1);
        chk("R3 core_enable applied", core_enable, 1'b1);

        // R2: unused bits read zero
        bus_write(5'h00, 8'hBE);
        bus_read(5'h00, v); chk("R2 unused bits zero", v, 8'h02);
        wait_idle(8'h02, ok);

        // R4: second enable write during busy is ignored, run-in-standby still taken
        bus_write(5'h00, 8'h00);
        bus_write(5'h00, 8'h42);
        bus_read(5'h00, v); chk("R4 enable write ignored while busy", v, 8'h40);
        wait_idle(8'h02, ok); chk("R4 busy clears", ok, 1'b1);
        chk("R4 core_enable from first write", core_enable, 1'b0);

        bus_write(5'h00, 8'h42);
        wait_idle(8'h02, ok);
        chk("R3 core_enable on", core_enable, 1'b1);

        // R6 / R7: software reset
        bus_write(5'h00, 8'h43);
        bus_write(5'h00, 8'h42);
        bus_read(5'h00, v); chk("R7 write during reset ignored", v, 8'h01);
        bus_read(5'h04, v); chk("R6 reset busy set", v, 8'h01);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            logic [7:0] c;
            bus_read(5'h04, v);
            #1;
            addr = 5'h00;
            #1 c = rdata;
            if (v[0] == 1'b0) begin
                ok = 1'b1;
                chk("R6 ctrl bit0 clears with busy", c, 8'h00);
                break;
            end else begin
                if (c != 8'h01) chk("R6 ctrl bit0 tracks busy", c, 8'h01);
            end
        end
        chk("R6 reset completes", ok, 1'b1);
        chk("R6 core disabled", core_enable, 1'b0);
        for (int i = 0; i < 4; i++) begin
            bus_read(keep_a[i], v); chk("R8 retained after reset", v, keep_m[i]);
        end

        // R2: unmapped offset
        bus_write(5'h1C, 8'hFF);
        bus_read(5'h1C, v); chk("R2 unmapped reads zero", v, 8'h00);

        // R9: directed decision table
        for (int rs = 0; rs < 2; rs++) begin
            bus_write(5'h00, rs[0] ? 8'h40 : 8'h00);
            for (int k = 0; k < 4; k++) begin
                @(negedge bus_clk);
                free_run = k[0];
                periph_req = k[1];
                #1 chk("R9 table", stby_run, exp_stby(rs[0], k[0], k[1]));
            end
            wait_idle(8'h02, ok);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule